// File: doc/BRIEF.md
# Host-to-Microcontroller Mailbox with Ownership

This block is a register-mapped mailbox that lets a host CPU and an embedded microcontroller exchange one message word in each direction. Each side reaches it through its own simple 32-bit register port. A three-state owner register decides who holds the mailbox: nobody, the microcontroller firmware, or host software. While somebody holds it, the host may post its outbound word to the microcontroller, and the microcontroller may answer with a word for the host. When the mailbox is free, both actions are refused.

The host side has five registers: command, data-in, data-out, owner and interrupt status. The command register carries an interrupt-enable bit and four destination bits. Setting the microcontroller destination together with enable posts the data-in word and raises the microcontroller interrupt. The host-notify destination together with enable drives the host interrupt. The microcontroller reads the posted word, writes its reply, releases or claims ownership, and sets status flags such as the firmware-hang flag. The host clears those flags by writing back what it read.

Both register ports are plain control buses with no back-pressure. A selected access is taken in the cycle it is presented. Read data returns one cycle later together with a one-cycle valid pulse, and the reader must take it in that cycle.

Top module: `hostmcu_mailbox`

## Requirements
- R1: After reset the owner is 0, the command, data-in, data-out and status registers read 0, and both interrupt outputs are low.
- R2: Host writes to the owner register at 0x0F0 are acted on as follows, with the whole 32-bit word compared. A word of 2 (held by software) takes effect only while the owner is 0 (free), so a readback of 1 or 2 reveals whether a claim failed. A word of 0 releases the mailbox. Any other word leaves the owner unchanged.
- R3: The microcontroller's owner register at 0x08 takes 1 (held by firmware) only while the owner is 0, and takes 0 as a release. When both ports change the owner in the same cycle, the host's effective change wins.
- R4: Message words hold an 8-bit type in bits 31:24 and a 24-bit payload in bits 23:0. The host data-in register at 0x0E8 reads back as written, and the microcontroller inbox at 0x00 returns the posted word unaltered.
- R5: A host write to the command register at 0x0E4 with bit 31 (enable) and bit 27 (microcontroller destination) set, while the owner is nonzero, copies data-in to the inbox and raises the microcontroller interrupt from the next cycle. Command bit 27 reads 1 while that post is pending. While the owner is 0, the same write posts nothing.
- R6: A microcontroller read of the inbox clears the pending post and the microcontroller interrupt. A post in the same cycle wins over this clear. Host writes of 0 to bit 27 have no effect.
- R7: A microcontroller write to its outbox at 0x04, while the owner is nonzero, updates the host data-out register at 0x0EC and sets command bit 29 (host notify). While the owner is 0, the write is ignored.
- R8: The host interrupt is high while command bits 31 and 29 are both 1. The host clears bit 29 by writing it as 0, but a microcontroller outbox write in the same cycle keeps it set. Bits 30 and 28 are stored and read back only.
- R9: Status at host 0x428 keeps bit 3 (enable) and bit 1 (firmware hang). Microcontroller writes to 0x0C set the bits that are written as 1. Host writes clear the bits that are written as 1. A set wins over a clear in the same cycle, and all other bits read 0.
- R10: Reads return data one cycle after the access, with a one-cycle valid pulse. Unmapped addresses, and command bits 26:0 other than bit 27, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 12 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | 32 | Host read data |
| m_sel | input | 1 | Microcontroller access strobe |
| m_we | input | 1 | Microcontroller write (1) or read (0) |
| m_addr | input | 5 | Microcontroller byte address |
| m_wdata | input | 32 | Microcontroller write data |
| m_rvalid | output | 1 | Microcontroller read data valid |
| m_rdata | output | 32 | Microcontroller read data |
| mcu_irq | output | 1 | Interrupt toward the microcontroller |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
A wrong owner state shows in the first owner readback after the access that caused it. It also shows in the very next post or outbox write: that access is accepted when it should be refused, or refused when it should be accepted. A lost or stale pending flag shows on mcu_irq one cycle after the post or the inbox read. A wrong inbox latch appears as a changed type or payload the next time the microcontroller reads its inbox. Status bits that fail to set or clear appear in the next host status read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // host-side byte offsets
  localparam logic [11:0] HA_CMD  = 12'h0E4;
  localparam logic [11:0] HA_DIN  = 12'h0E8;
  localparam logic [11:0] HA_DOUT = 12'h0EC;
  localparam logic [11:0] HA_OWN  = 12'h0F0;
  localparam logic [11:0] HA_STAT = 12'h428;
  // microcontroller-side byte offsets
  localparam logic [4:0] MA_INBOX  = 5'h00;
  localparam logic [4:0] MA_OUTBOX = 5'h04;
  localparam logic [4:0] MA_OWN    = 5'h08;
  localparam logic [4:0] MA_STAT   = 5'h0C;
  // command bit positions
  localparam int CB_IEN  = 31;
  localparam int CB_HC   = 30;
  localparam int CB_HNTF = 29;
  localparam int CB_PME  = 28;
  localparam int CB_MCU  = 27;
  // status bit positions
  localparam int SB_EN   = 3;
  localparam int SB_HANG = 1;

  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_FW   = 2'd1,
    OWN_SW   = 2'd2
  } owner_e;
endpackage

// File: rtl/mbx_owner.sv
module mbx_owner
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [DATA_W-1:0] h_val,
  input  logic              m_wr,
  input  logic [DATA_W-1:0] m_val,
  output logic [1:0]        owner
);
  owner_e owner_q, owner_d;
  logic   h_hit;

  always_comb begin
    owner_d = owner_q;
    h_hit   = 1'b0;
    if (h_wr) begin
      if (h_val == DATA_W'(OWN_SW) && owner_q == OWN_FREE) begin
        owner_d = OWN_SW;
        h_hit   = 1'b1;
      end else if (h_val == '0 && owner_q != OWN_FREE) begin
        owner_d = OWN_FREE;
        h_hit   = 1'b1;
      end
    end
    if (m_wr && !h_hit) begin
      if (m_val == DATA_W'(OWN_FW) && owner_q == OWN_FREE) owner_d = OWN_FW;
      else if (m_val == '0) owner_d = OWN_FREE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_FREE;
    else        owner_q <= owner_d;
  end

  assign owner = owner_q;

  a_r2_claim_free: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_val == DATA_W'(2) && owner == 2'd0) |=> owner == 2'd2)
    else $error("claim of free mailbox lost");
  a_r2_claim_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_val == DATA_W'(2) && owner != 2'd0 && !m_wr) |=> $stable(owner))
    else $error("claim of held mailbox changed owner");
  a_r3_fw_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && m_val == DATA_W'(1) && owner == 2'd0 && !h_wr) |=> owner == 2'd1)
    else $error("firmware claim lost");
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic [DATA_W-1:0] set_bits,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_bits,
  output logic [DATA_W-1:0] stat
);
  localparam logic [DATA_W-1:0] KEEP = (DATA_W'(1) << SB_EN) | (DATA_W'(1) << SB_HANG);
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] clr_m, set_m;

  assign clr_m = clr_we ? clr_bits : '0;
  assign set_m = set_we ? set_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((stat_q & ~clr_m) | set_m) & KEEP;
  end

  assign stat = stat_q;

  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[SB_HANG] && !set_we) |=> !stat[SB_HANG])
    else $error("hang flag not cleared");
  a_r9_w1s: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && set_bits[SB_HANG]) |=> stat[SB_HANG])
    else $error("hang flag not set");
endmodule

// File: rtl/mbx_cmd.sv
module mbx_cmd
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_cmd_we,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [DATA_W-1:0] din,
  input  logic              owner_busy,
  input  logic              m_inbox_rd,
  input  logic              m_out_we,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] cmd_word,
  output logic [DATA_W-1:0] inbox,
  output logic [DATA_W-1:0] outbox,
  output logic              mcu_irq,
  output logic              host_irq
);
  logic ien_q, hc_q, hntf_q, pme_q, pend_q;
  logic [DATA_W-1:0] inbox_q, outbox_q;
  logic post, out_ok;

  assign post   = h_cmd_we && h_wdata[CB_IEN] && h_wdata[CB_MCU] && owner_busy;
  assign out_ok = m_out_we && owner_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q    <= 1'b0;
      hc_q     <= 1'b0;
      hntf_q   <= 1'b0;
      pme_q    <= 1'b0;
      pend_q   <= 1'b0;
      inbox_q  <= '0;
      outbox_q <= '0;
    end else begin
      if (h_cmd_we) begin
        ien_q <= h_wdata[CB_IEN];
        hc_q  <= h_wdata[CB_HC];
        pme_q <= h_wdata[CB_PME];
      end
      if (out_ok)        hntf_q <= 1'b1;
      else if (h_cmd_we) hntf_q <= h_wdata[CB_HNTF];
      if (post)            pend_q <= 1'b1;
      else if (m_inbox_rd) pend_q <= 1'b0;
      if (post)   inbox_q  <= din;
      if (out_ok) outbox_q <= m_wdata;
    end
  end

  always_comb begin
    cmd_word          = '0;
    cmd_word[CB_IEN]  = ien_q;
    cmd_word[CB_HC]   = hc_q;
    cmd_word[CB_HNTF] = hntf_q;
    cmd_word[CB_PME]  = pme_q;
    cmd_word[CB_MCU]  = pend_q;
  end

  assign inbox    = inbox_q;
  assign outbox   = outbox_q;
  assign mcu_irq  = pend_q;
  assign host_irq = ien_q & hntf_q;

  a_r5_post: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cmd_we && h_wdata[CB_IEN] && h_wdata[CB_MCU] && owner_busy) |=> (mcu_irq && inbox == $past(din)))
    else $error("post not latched");
  a_r6_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (m_inbox_rd && !h_cmd_we) |=> !mcu_irq)
    else $error("inbox read did not clear interrupt");
  a_r7_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (m_out_we && !owner_busy) |=> $stable(outbox))
    else $error("outbox written while free");
  a_r8_notify: assert property (@(posedge clk) disable iff (!rst_n)
    (m_out_we && owner_busy && !h_cmd_we && cmd_word[CB_IEN]) |=> host_irq)
    else $error("host not interrupted");
endmodule

// File: rtl/hostmcu_mailbox.sv
module hostmcu_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HADDR_W = 12,
  parameter int MADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_sel,
  input  logic               h_we,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0]  h_wdata,
  output logic               h_rvalid,
  output logic [DATA_W-1:0]  h_rdata,
  input  logic               m_sel,
  input  logic               m_we,
  input  logic [MADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0]  m_wdata,
  output logic               m_rvalid,
  output logic [DATA_W-1:0]  m_rdata,
  output logic               mcu_irq,
  output logic               host_irq
);
  logic h_wr, h_rd, m_wr, m_rd;
  logic [DATA_W-1:0] din_q, cmd_word, inbox, outbox, stat;
  logic [1:0] owner;
  logic [DATA_W-1:0] h_mux, m_mux;

  assign h_wr = h_sel & h_we;
  assign h_rd = h_sel & ~h_we;
  assign m_wr = m_sel & m_we;
  assign m_rd = m_sel & ~m_we;

  always_ff @(posedge clk) begin
    if (!rst_n) din_q <= '0;
    else if (h_wr && h_addr == HADDR_W'(HA_DIN)) din_q <= h_wdata;
  end

  mbx_owner #(.DATA_W(DATA_W)) u_owner (
    .clk   (clk),
    .rst_n (rst_n),
    .h_wr  (h_wr && h_addr == HADDR_W'(HA_OWN)),
    .h_val (h_wdata),
    .m_wr  (m_wr && m_addr == MADDR_W'(MA_OWN)),
    .m_val (m_wdata),
    .owner (owner)
  );

  mbx_status #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (m_wr && m_addr == MADDR_W'(MA_STAT)),
    .set_bits (m_wdata),
    .clr_we   (h_wr && h_addr == HADDR_W'(HA_STAT)),
    .clr_bits (h_wdata),
    .stat     (stat)
  );

  mbx_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_cmd_we   (h_wr && h_addr == HADDR_W'(HA_CMD)),
    .h_wdata    (h_wdata),
    .din        (din_q),
    .owner_busy (owner != 2'd0),
    .m_inbox_rd (m_rd && m_addr == MADDR_W'(MA_INBOX)),
    .m_out_we   (m_wr && m_addr == MADDR_W'(MA_OUTBOX)),
    .m_wdata    (m_wdata),
    .cmd_word   (cmd_word),
    .inbox      (inbox),
    .outbox     (outbox),
    .mcu_irq    (mcu_irq),
    .host_irq   (host_irq)
  );

  always_comb begin
    h_mux = '0;
    if      (h_addr == HADDR_W'(HA_CMD))  h_mux = cmd_word;
    else if (h_addr == HADDR_W'(HA_DIN))  h_mux = din_q;
    else if (h_addr == HADDR_W'(HA_DOUT)) h_mux = outbox;
    else if (h_addr == HADDR_W'(HA_OWN))  h_mux = DATA_W'(owner);
    else if (h_addr == HADDR_W'(HA_STAT)) h_mux = stat;
  end

  always_comb begin
    m_mux = '0;
    if      (m_addr == MADDR_W'(MA_INBOX))  m_mux = inbox;
    else if (m_addr == MADDR_W'(MA_OUTBOX)) m_mux = outbox;
    else if (m_addr == MADDR_W'(MA_OWN))    m_mux = DATA_W'(owner);
    else if (m_addr == MADDR_W'(MA_STAT))   m_mux = stat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
      m_rvalid <= 1'b0;
      m_rdata  <= '0;
    end else begin
      h_rvalid <= h_rd;
      m_rvalid <= m_rd;
      if (h_rd) h_rdata <= h_mux;
      if (m_rd) m_rdata <= m_mux;
    end
  end

  a_r10_hvalid: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid |-> $past(h_sel && !h_we))
    else $error("spurious host read valid");
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mcu_irq) |-> $past(m_sel && !m_we))
    else $error("microcontroller interrupt dropped without inbox read");
endmodule

// File: tb/hostmcu_mailbox_tb.sv
module hostmcu_mailbox_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_sel = 0, h_we = 0, m_sel = 0, m_we = 0;
  logic [11:0] h_addr = '0;
  logic [4:0]  m_addr = '0;
  logic [31:0] h_wdata = '0, m_wdata = '0;
  logic h_rvalid, m_rvalid, mcu_irq, host_irq;
  logic [31:0] h_rdata, m_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [11:0] CMD = 12'h0E4, DIN = 12'h0E8, DOUT = 12'h0EC, OWN = 12'h0F0, STAT = 12'h428;
  localparam logic [4:0] INB = 5'h00, OUTB = 5'h04, MOWN = 5'h08, MSTAT = 5'h0C;

  always #10 clk = ~clk;

  hostmcu_mailbox u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [11:0] a, input logic [31:0] d);
    h_sel = 1; h_we = 1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_sel = 0; h_we = 0;
  endtask

  task automatic hr(input logic [11:0] a, output logic [31:0] d);
    h_sel = 1; h_we = 0; h_addr = a;
    @(negedge clk);
    d = h_rvalid ? h_rdata : 32'hDEAD_BEEF;
    h_sel = 0;
  endtask

  task automatic mw(input logic [4:0] a, input logic [31:0] d);
    m_sel = 1; m_we = 1; m_addr = a; m_wdata = d;
    @(negedge clk);
    m_sel = 0; m_we = 0;
  endtask

  task automatic mr(input logic [4:0] a, output logic [31:0] d);
    m_sel = 1; m_we = 0; m_addr = a;
    @(negedge clk);
    d = m_rvalid ? m_rdata : 32'hDEAD_BEEF;
    m_sel = 0;
  endtask

  // owner model from R2/R3
  function automatic logic [1:0] own_model(input logic [1:0] cur, input bit hdo, input logic [31:0] hv,
                                           input bit mdo, input logic [31:0] mv);
    logic [1:0] n = cur;
    bit hit = 0;
    if (hdo) begin
      if (hv == 32'd2 && cur == 2'd0) begin n = 2'd2; hit = 1; end
      else if (hv == 32'd0 && cur != 2'd0) begin n = 2'd0; hit = 1; end
    end
    if (mdo && !hit) begin
      if (mv == 32'd1 && cur == 2'd0) n = 2'd1;
      else if (mv == 32'd0) n = 2'd0;
    end
    return n;
  endfunction

  function automatic logic [31:0] pick_val();
    case ($urandom % 4)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'd2;
      default: return $urandom;
    endcase
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [1:0] cur;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 mcu_irq", {31'd0, mcu_irq}, 0);
    chk("R1 host_irq", {31'd0, host_irq}, 0);
    hr(OWN, rd);  chk("R1 owner", rd, 0);
    hr(CMD, rd);  chk("R1 cmd", rd, 0);
    hr(STAT, rd); chk("R1 status", rd, 0);
    hr(DOUT, rd); chk("R1 dout", rd, 0);

    // R10 read latency and unmapped read
    h_sel = 1; h_we = 0; h_addr = 12'h100;
    @(negedge clk);
    chk("R10 rvalid", {31'd0, h_rvalid}, 1);
    chk("R10 unmapped", h_rdata, 0);
    h_sel = 0;
    @(negedge clk);
    chk("R10 rvalid pulse", {31'd0, h_rvalid}, 0);

    // R2 claim, ignored values
    hw(OWN, 32'd2); hr(OWN, rd); chk("R2 claim", rd, 2);
    hw(OWN, 32'h102); hr(OWN, rd); chk("R2 ignore other", rd, 2);

    // R4 data-in readback
    hw(DIN, 32'h12_345678); hr(DIN, rd); chk("R4 din", rd, 32'h12345678);

    // R5 post
    hw(CMD, 32'h8800_0000);
    chk("R5 mcu_irq", {31'd0, mcu_irq}, 1);
    hr(CMD, rd); chk("R5 cmd pending", rd, 32'h8800_0000);
    hw(CMD, 32'h8000_0000);
    chk("R6 write0 no effect", {31'd0, mcu_irq}, 1);
    mr(INB, rd); chk("R4 inbox", rd, 32'h12345678);
    chk("R6 consumed", {31'd0, mcu_irq}, 0);

    // R7/R8 reply path
    mw(OUTB, 32'h80_00ABCD);
    chk("R8 host_irq", {31'd0, host_irq}, 1);
    hr(DOUT, rd); chk("R7 dout", rd, 32'h8000ABCD);
    hr(CMD, rd); chk("R8 cmd notify", rd, 32'hA000_0000);
    hw(CMD, 32'h5000_0000);
    chk("R8 cleared", {31'd0, host_irq}, 0);
    hr(CMD, rd); chk("R8 stored bits", rd, 32'h5000_0000);
    // clear vs set same cycle
    h_sel = 1; h_we = 1; h_addr = CMD; h_wdata = 32'h8000_0000;
    m_sel = 1; m_we = 1; m_addr = OUTB; m_wdata = 32'h81_000001;
    @(negedge clk);
    h_sel = 0; h_we = 0; m_sel = 0; m_we = 0;
    chk("R8 set wins", {31'd0, host_irq}, 1);
    hw(CMD, 32'h0);

    // release, then refused post and outbox
    hw(OWN, 32'd0); hr(OWN, rd); chk("R2 release", rd, 0);
    hw(DIN, 32'h55_000055);
    hw(CMD, 32'h8800_0000);
    chk("R5 free no post", {31'd0, mcu_irq}, 0);
    hr(CMD, rd); chk("R5 free cmd", rd, 32'h8000_0000);
    mw(OUTB, 32'h77_777777);
    hr(DOUT, rd); chk("R7 free ignored", rd, 32'h81000001);
    chk("R7 no notify", {31'd0, host_irq}, 0);

    // R3 firmware claim and failed host claim
    mw(MOWN, 32'd1); hr(OWN, rd); chk("R3 fw claim", rd, 1);
    hw(OWN, 32'd2); hr(OWN, rd); chk("R2 failed claim", rd, 1);
    mw(MOWN, 32'd0); hr(OWN, rd); chk("R3 fw release", rd, 0);
    // simultaneous claims: host wins
    h_sel = 1; h_we = 1; h_addr = OWN; h_wdata = 32'd2;
    m_sel = 1; m_we = 1; m_addr = MOWN; m_wdata = 32'd1;
    @(negedge clk);
    h_sel = 0; h_we = 0; m_sel = 0; m_we = 0;
    mr(MOWN, rd); chk("R3 host priority", rd, 2);

    // R6 post and consume same cycle
    hw(DIN, 32'hC3_0000FF);
    hw(CMD, 32'h8800_0000);
    h_sel = 1; h_we = 1; h_addr = CMD; h_wdata = 32'h8800_0000;
    m_sel = 1; m_we = 0; m_addr = INB;
    @(negedge clk);
    h_sel = 0; h_we = 0; m_sel = 0;
    chk("R6 post wins", {31'd0, mcu_irq}, 1);
    mr(INB, rd); chk("R4 inbox2", rd, 32'hC30000FF);

    // R9 status
    mw(MSTAT, 32'hFFFF_FFFF); hr(STAT, rd); chk("R9 set mask", rd, 32'hA);
    hw(STAT, 32'h2); hr(STAT, rd); chk("R9 w1c", rd, 32'h8);
    h_sel = 1; h_we = 1; h_addr = STAT; h_wdata = 32'h2;
    m_sel = 1; m_we = 1; m_addr = MSTAT; m_wdata = 32'h2;
    @(negedge clk);
    h_sel = 0; h_we = 0; m_sel = 0; m_we = 0;
    hr(STAT, rd); chk("R9 set wins", rd, 32'hA);
    hw(STAT, rd); hr(STAT, rd); chk("R9 writeback clears", rd, 0);

    // random owner traffic against the model
    hr(OWN, rd); cur = rd[1:0];
    for (int i = 0; i < 300; i++) begin
      bit hdo, mdo;
      logic [31:0] hv, mv, w;
      logic [1:0] exp;
      hdo = ($urandom % 2) == 1; mdo = ($urandom % 2) == 1;
      hv = pick_val(); mv = pick_val();
      h_sel = hdo; h_we = hdo; h_addr = OWN; h_wdata = hv;
      m_sel = mdo; m_we = mdo; m_addr = MOWN; m_wdata = mv;
      @(negedge clk);
      h_sel = 0; h_we = 0; m_sel = 0; m_we = 0;
      exp = own_model(cur, hdo, hv, mdo, mv);
      hr(OWN, rd); chk("R3 random owner", rd, {30'd0, exp});
      cur = exp;
      if (i % 5 == 0) begin
        w = $urandom;
        hw(DIN, w);
        hw(CMD, 32'h8800_0000);
        chk("R5 random post", {31'd0, mcu_irq}, (cur != 0) ? 1 : 0);
        if (cur != 0) begin
          mr(INB, rd); chk("R4 random word", rd, w);
        end
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule